// File: doc/BRIEF.md
# Gated Interval Timer with Toggle Gate Conditioning

This block is a 16-bit up-counter whose counting is qualified by a conditioned gate signal. The gate comes from one of three live sources: an external pin, a comparator result, or the one-cycle overflow pulse of a neighbouring timer. A fourth selection holds the raw gate at logic 0. The selected gate is first inverted or passed according to a polarity bit. It then either drives the count qualifier directly, or goes through a toggle stage. The toggle stage flips on every rising edge of the polarised gate, so the counter accumulates across one whole gate period instead of only the active phase.

On top of either path, a single-pulse capture can be armed. The capture waits for a fresh rising edge of the conditioned gate and counts while that gate stays active. When the gate drops, it clears its own arm bit and raises a sticky gate-event interrupt flag. Software sets up the block through one 8-bit control word and may preload the counter. An external prescaler supplies a per-cycle count-enable tick.

The toggle flip-flop is forced to 0, and held there, whenever the timer is switched off or toggle mode is disabled. Software can therefore decide which gate edge starts a period measurement.

Top module: `gtt_timer`

## Requirements
- R1: After reset, count_o, ctl_q, ovf_o and irq_o are all 0.
- R2: Control bits [7:6] choose the raw gate: 0 = gate_pin, 1 = gate_cmp, 2 = gate_ovf, 3 = constant 0.
- R3: Control bit 5 sets the polarity. With 1 the raw gate is active when high; with 0 it is inverted before any further stage.
- R4: Control bit 0 (run) must be 1 for any counting. With control bit 1 (gate enable) at 0, every tick counts. With it at 1, a tick counts only while the conditioned gate is active.
- R5: With control bit 2 (toggle) set, the conditioned gate is a flip-flop that inverts one cycle after each rising edge of the polarised gate.
- R6: While toggle or run is 0, the toggle flip-flop is 0 and stays 0. After re-enabling, counting under toggle waits for the next rising edge.
- R7: With control bit 3 (single-pulse) and bit 4 (arm) set, counting starts only on a rising edge of the conditioned gate seen after arming; a gate already active does not open it. Counting continues while the gate stays active. The first inactive cycle closes the window, clears bit 4 and sets irq_o. Nothing counts again until re-armed.
- R8: irq_o is sticky. A cycle with irq_clr high clears it, unless a capture completes in the same cycle, which wins.
- R9: The counter wraps from 0xFFFF to 0x0000, and ovf_o is high for exactly the one cycle after that wrap.
- R10: cnt_we loads cnt_wdata into the counter and takes priority over an increment in the same cycle.
- R11: ctl_we loads the whole control word, which reads back on ctl_q. A write takes priority over the hardware clear of the arm bit.
- R12: A cycle with cnt_tick low never increments the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write value |
| ctl_q | output | 8 | Current control word |
| cnt_tick | input | 1 | Count enable from the prescaler |
| gate_pin | input | 1 | External pin gate source (synchronous) |
| gate_cmp | input | 1 | Comparator gate source (synchronous) |
| gate_ovf | input | 1 | Neighbour timer overflow pulse |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 16 | Counter load value |
| count_o | output | 16 | Counter value |
| ovf_o | output | 1 | One-cycle overflow pulse |
| irq_clr | input | 1 | Clears the gate-event flag |
| irq_o | output | 1 | Sticky gate-event flag |

## Verification
A toggle flip-flop that is left set after a clear shows up as counting that starts too early. After run or toggle is re-enabled with the gate idle, count_o starts moving on the very next tick instead of after the next rising edge; the bench sets up exactly that idle window. A stuck or premature single-pulse window is visible within one cycle of a gate edge as an extra or missing increment. It is also visible as arm bit 4 on ctl_q and irq_o not changing together. The reference model is compared against count_o, ovf_o, irq_o and ctl_q after every edge, so any divergence is reported in the cycle it first appears.

// File: rtl/gtt_pkg.sv
package gtt_pkg;
  localparam int SRC_N = 4;
  localparam int SEL_W = $clog2(SRC_N);

  // control word, msb first: src, pol, arm, pmode, tog_en, gate_en, run
  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic             pol;
    logic             arm;
    logic             pmode;
    logic             tog_en;
    logic             gate_en;
    logic             run;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/gtt_gate_cond.sv
module gtt_gate_cond
  import gtt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_vec,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  input  logic             run,
  input  logic             tog_en,
  output logic             gate_c,
  output logic             tog_q
);
  logic gate_raw;
  logic gate_p;
  logic gate_p_q;
  logic rise;
  logic tog_n;

  always_comb begin
    gate_raw = src_vec[sel];
    gate_p   = pol ? gate_raw : ~gate_raw;
    rise     = gate_p & ~gate_p_q;
    if (!run || !tog_en) begin
      tog_n = 1'b0;
    end else if (rise) begin
      tog_n = ~tog_q;
    end else begin
      tog_n = tog_q;
    end
    gate_c = tog_en ? tog_q : gate_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_p_q <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      gate_p_q <= gate_p;
      tog_q    <= tog_n;
    end
  end
endmodule

// File: rtl/gtt_pulse_ctl.sv
module gtt_pulse_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_c,
  input  logic pmode,
  input  logic arm,
  output logic gate_eff,
  output logic done
);
  logic gate_c_q;
  logic grise;
  logic open_q;
  logic open_n;

  always_comb begin
    grise = gate_c & ~gate_c_q;
    done  = pmode & arm & open_q & ~gate_c;
    if (pmode) begin
      gate_eff = arm & ((~open_q & grise) | (open_q & gate_c));
    end else begin
      gate_eff = gate_c;
    end
    if (!pmode || !arm) begin
      open_n = 1'b0;
    end else if (!open_q && grise) begin
      open_n = 1'b1;
    end else if (open_q && !gate_c) begin
      open_n = 1'b0;
    end else begin
      open_n = open_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_c_q <= 1'b0;
      open_q   <= 1'b0;
    end else begin
      gate_c_q <= gate_c;
      open_q   <= open_n;
    end
  end
endmodule

// File: rtl/gtt_counter.sv
module gtt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_n;
  logic             ovf_n;

  always_comb begin
    cnt_n = cnt_q;
    ovf_n = 1'b0;
    if (ld) begin
      cnt_n = ld_val;
    end else if (inc) begin
      cnt_n = cnt_q + 1'b1;
      ovf_n = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end
endmodule

// File: rtl/gtt_timer.sv
module gtt_timer
  import gtt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             cnt_tick,
  input  logic             gate_pin,
  input  logic             gate_cmp,
  input  logic             gate_ovf,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  input  logic             irq_clr,
  output logic             irq_o
);
  logic [1:0]       rst_sync;
  logic             rst_s_n;
  ctl_t             ctl_r;
  ctl_t             ctl_n;
  logic             irq_n;
  logic [SRC_N-1:0] src_vec;
  logic             gate_c;
  logic             tog_state;
  logic             gate_eff;
  logic             sp_done;
  logic             cnt_inc;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync[1];

  assign src_vec = {1'b0, gate_ovf, gate_cmp, gate_pin};

  gtt_gate_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .src_vec (src_vec),
    .sel     (ctl_r.src),
    .pol     (ctl_r.pol),
    .run     (ctl_r.run),
    .tog_en  (ctl_r.tog_en),
    .gate_c  (gate_c),
    .tog_q   (tog_state)
  );

  gtt_pulse_ctl u_pulse (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .gate_c   (gate_c),
    .pmode    (ctl_r.pmode),
    .arm      (ctl_r.arm),
    .gate_eff (gate_eff),
    .done     (sp_done)
  );

  assign cnt_inc = ctl_r.run & cnt_tick & (~ctl_r.gate_en | gate_eff);

  gtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .inc    (cnt_inc),
    .ld     (cnt_we),
    .ld_val (cnt_wdata),
    .cnt_q  (count_o),
    .ovf_q  (ovf_o)
  );

  always_comb begin
    ctl_n = ctl_r;
    if (ctl_we) begin
      ctl_n = ctl_t'(ctl_wdata);
    end else if (sp_done) begin
      ctl_n.arm = 1'b0;
    end
    if (sp_done) begin
      irq_n = 1'b1;
    end else if (irq_clr) begin
      irq_n = 1'b0;
    end else begin
      irq_n = irq_o;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctl_r <= '0;
      irq_o <= 1'b0;
    end else begin
      ctl_r <= ctl_n;
      irq_o <= irq_n;
    end
  end

  assign ctl_q = ctl_r;
endmodule

// File: rtl/gtt_timer_chk.sv
module gtt_timer_chk #(
  parameter int CNT_W = 16,
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic [CTL_W-1:0] ctl_q,
  input logic             ctl_we,
  input logic             cnt_tick,
  input logic             cnt_we,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             irq_clr,
  input logic             irq_o,
  input logic             tog_state
);
  // R6: toggle state cleared and held while run or toggle is off
  a_r6_tog_held_clear: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ctl_q[0] || !ctl_q[2]) |=> !tog_state);

  // R9: overflow pulse only with a wrapped counter, and never two in a row
  a_r9_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    ovf_o |-> (count_o == '0));
  a_r9_ovf_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    ovf_o |=> !ovf_o);

  // R12: no tick and no load keeps the count
  a_r12_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cnt_tick && !cnt_we) |=> $stable(count_o));

  // R4: timer off keeps the count
  a_r4_off_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ctl_q[0] && !cnt_we) |=> $stable(count_o));

  // R8: flag stays set until cleared
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_o && !irq_clr) |=> irq_o);

  // R7: hardware clear of arm comes with the event flag
  a_r7_arm_clear_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($fell(ctl_q[4]) && !$past(ctl_we)) |-> irq_o);
endmodule

bind gtt_timer gtt_timer_chk #(.CNT_W(CNT_W), .CTL_W(gtt_pkg::CTL_W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .ctl_q     (ctl_q),
  .ctl_we    (ctl_we),
  .cnt_tick  (cnt_tick),
  .cnt_we    (cnt_we),
  .count_o   (count_o),
  .ovf_o     (ovf_o),
  .irq_clr   (irq_clr),
  .irq_o     (irq_o),
  .tog_state (tog_state)
);

// File: tb/gtt_timer_bench.sv
`timescale 1ns/1ps
module gtt_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic [7:0]  ctl_q;
  logic        cnt_tick;
  logic        gate_pin;
  logic        gate_cmp;
  logic        gate_ovf;
  logic        cnt_we;
  logic [15:0] cnt_wdata;
  logic [15:0] count_o;
  logic        ovf_o;
  logic        irq_clr;
  logic        irq_o;

  int    n_chk;
  int    n_fail;
  string cur_tag;

  // reference model state
  int m_cnt, m_ctl;
  bit m_ovf, m_irq, m_gpq, m_tog, m_gtq, m_open;

  gtt_timer u_gtt_timer (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .cnt_tick(cnt_tick), .gate_pin(gate_pin), .gate_cmp(gate_cmp), .gate_ovf(gate_ovf),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .count_o(count_o), .ovf_o(ovf_o),
    .irq_clr(irq_clr), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] cw(int src, bit pol, bit arm, bit pm, bit tog, bit gen, bit run);
    return {src[1:0], pol, arm, pm, tog, gen, run};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit raw, gp, rise, gt, grise, eff, done, inc;
    bit run, gen, tog_en, pm, arm, pol;
    int src;
    src = (m_ctl >> 6) & 3; pol = m_ctl[5]; arm = m_ctl[4]; pm = m_ctl[3];
    tog_en = m_ctl[2]; gen = m_ctl[1]; run = m_ctl[0];
    case (src)
      0: raw = gate_pin;
      1: raw = gate_cmp;
      2: raw = gate_ovf;
      default: raw = 1'b0;
    endcase
    gp    = pol ? raw : !raw;
    rise  = gp && !m_gpq;
    gt    = tog_en ? m_tog : gp;
    grise = gt && !m_gtq;
    if (pm) eff = arm && ((!m_open && grise) || (m_open && gt));
    else    eff = gt;
    done = pm && arm && m_open && !gt;
    inc  = run && cnt_tick && (!gen || eff);
    m_gpq = gp;
    if (!run || !tog_en) m_tog = 0; else if (rise) m_tog = !m_tog;
    m_gtq = gt;
    if (!pm || !arm) m_open = 0;
    else if (!m_open && grise) m_open = 1;
    else if (m_open && !gt) m_open = 0;
    if (ctl_we) m_ctl = ctl_wdata; else if (done) m_ctl = m_ctl & 8'hEF;
    m_ovf = 0;
    if (cnt_we) m_cnt = cnt_wdata;
    else if (inc) begin
      m_ovf = (m_cnt == 16'hFFFF);
      m_cnt = (m_cnt + 1) & 16'hFFFF;
    end
    if (done) m_irq = 1; else if (irq_clr) m_irq = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(cur_tag, "count_o", count_o, m_cnt);
    chk(cur_tag, "ovf_o", ovf_o, m_ovf);
    chk(cur_tag, "irq_o", irq_o, m_irq);
    chk(cur_tag, "ctl_q", ctl_q, m_ctl);
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic ld_cnt(logic [15:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    step();
    cnt_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int base;
    n_chk = 0; n_fail = 0; cur_tag = "R1";
    m_cnt = 0; m_ctl = 0; m_ovf = 0; m_irq = 0;
    m_gpq = 0; m_tog = 0; m_gtq = 0; m_open = 0;
    rst_n = 1'b0; ctl_we = 0; ctl_wdata = 0; cnt_tick = 0;
    gate_pin = 0; gate_cmp = 0; gate_ovf = 0; cnt_we = 0; cnt_wdata = 0; irq_clr = 0;
    repeat (3) @(negedge clk);
    chk("R1", "count_o", count_o, 0);
    chk("R1", "ctl_q", ctl_q, 0);
    chk("R1", "ovf_o", ovf_o, 0);
    chk("R1", "irq_o", irq_o, 0);
    rst_n = 1'b1;
    repeat (3) step();

    // R4 free running with gating off, R12 tick low
    cur_tag = "R4";
    cnt_tick = 1;
    wr_ctl(cw(0, 1, 0, 0, 0, 0, 1));
    repeat (5) step();
    chk("R4", "count after 5 ticks", count_o, 5);
    cur_tag = "R12";
    cnt_tick = 0;
    repeat (3) step();
    chk("R12", "count with tick low", count_o, 5);
    for (int i = 0; i < 8; i++) begin cnt_tick = i[0]; step(); end
    cur_tag = "R4";
    cnt_tick = 1;
    wr_ctl(cw(0, 1, 0, 0, 0, 0, 0));
    base = count_o;
    repeat (3) step();
    chk("R4", "count with run off", count_o, base);

    // R10 load, R2/R3 source and polarity
    cur_tag = "R10";
    ld_cnt(16'h0000);
    chk("R10", "count after load", count_o, 0);
    cur_tag = "R2";
    wr_ctl(cw(0, 1, 0, 0, 0, 1, 1));
    for (int i = 0; i < 12; i++) begin gate_pin = (i % 3 == 0); step(); end
    gate_pin = 0;
    wr_ctl(cw(1, 1, 0, 0, 0, 1, 1));
    for (int i = 0; i < 12; i++) begin gate_cmp = (i % 4 != 1); gate_pin = i[0]; step(); end
    wr_ctl(cw(2, 1, 0, 0, 0, 1, 1));
    for (int i = 0; i < 12; i++) begin gate_ovf = (i % 5 == 2); step(); end
    gate_ovf = 0;
    wr_ctl(cw(3, 1, 0, 0, 0, 1, 1));
    base = count_o;
    gate_pin = 1; gate_cmp = 1;
    repeat (4) step();
    chk("R2", "count with constant source", count_o, base);
    cur_tag = "R3";
    wr_ctl(cw(3, 0, 0, 0, 0, 1, 1));
    base = count_o;
    repeat (4) step();
    chk("R3", "inverted constant counts", count_o, base + 4);
    wr_ctl(cw(0, 0, 0, 0, 0, 1, 1));
    for (int i = 0; i < 10; i++) begin gate_pin = (i % 4 < 1); step(); end

    // R5 toggle period measurement
    cur_tag = "R5";
    gate_pin = 0;
    wr_ctl(cw(0, 1, 0, 0, 1, 1, 1));
    ld_cnt(16'h0000);
    for (int i = 0; i < 40; i++) begin gate_pin = (i % 8 < 3); step(); end

    // R6 clearing toggle enable or run resets the flip-flop
    cur_tag = "R6";
    gate_pin = 1; step(); step();
    gate_pin = 0; step();
    if (m_tog) begin
      wr_ctl(cw(0, 1, 0, 0, 0, 1, 1));
      wr_ctl(cw(0, 1, 0, 0, 1, 1, 1));
    end
    gate_pin = 1; step(); step();
    gate_pin = 0; step();
    wr_ctl(cw(0, 1, 0, 0, 0, 1, 1));
    wr_ctl(cw(0, 1, 0, 0, 1, 1, 1));
    base = count_o;
    repeat (4) step();
    chk("R6", "count after toggle re-enable", count_o, base);
    gate_pin = 1; step(); step();
    gate_pin = 0; step();
    wr_ctl(cw(0, 1, 0, 0, 1, 1, 0));
    wr_ctl(cw(0, 1, 0, 0, 1, 1, 1));
    base = count_o;
    repeat (4) step();
    chk("R6", "count after run re-enable", count_o, base);

    // R7 single pulse
    cur_tag = "R7";
    gate_pin = 1;
    wr_ctl(cw(0, 1, 0, 1, 0, 1, 1));
    ld_cnt(16'h0000);
    wr_ctl(cw(0, 1, 1, 1, 0, 1, 1));
    repeat (3) step();
    chk("R7", "no count while already high", count_o, 0);
    gate_pin = 0; repeat (2) step();
    gate_pin = 1; repeat (4) step();
    gate_pin = 0; step();
    chk("R7", "pulse width count", count_o, 4);
    chk("R7", "arm bit cleared", ctl_q[4], 0);
    chk("R7", "event flag", irq_o, 1);
    gate_pin = 1; repeat (3) step();
    gate_pin = 0; step();
    chk("R7", "no count when unarmed", count_o, 4);

    // R8 flag clear
    cur_tag = "R8";
    step();
    chk("R8", "flag held", irq_o, 1);
    irq_clr = 1; step(); irq_clr = 0;
    chk("R8", "flag cleared", irq_o, 0);

    // R11 write wins over hardware arm clear
    cur_tag = "R11";
    wr_ctl(cw(0, 1, 1, 1, 0, 1, 1));
    gate_pin = 1; step(); step();
    gate_pin = 0;
    wr_ctl(cw(0, 1, 1, 1, 0, 1, 1));
    chk("R11", "arm after write on completion", ctl_q[4], 1);
    chk("R8", "set on completion", irq_o, 1);
    wr_ctl(8'h96);
    chk("R11", "ctl readback", ctl_q, 8'h96);

    // R9 wrap and overflow pulse
    cur_tag = "R9";
    wr_ctl(cw(0, 1, 0, 0, 0, 0, 1));
    ld_cnt(16'hFFFE);
    step();
    chk("R9", "count before wrap", count_o, 16'hFFFF);
    step();
    chk("R9", "count wrapped", count_o, 0);
    chk("R9", "ovf pulse", ovf_o, 1);
    step();
    chk("R9", "ovf one cycle", ovf_o, 0);

    // R10 load beats increment
    cur_tag = "R10";
    ld_cnt(16'h1234);
    chk("R10", "load priority", count_o, 16'h1234);
    ld_cnt(16'hFFFF);
    cnt_tick = 0; step();
    chk("R10", "loaded max held", count_o, 16'hFFFF);
    repeat (2) step();

    finish_run();
  end
endmodule